// File: doc/BRIEF.md
# Row-Unrolled Four-Point Stencil Element

This block is a streaming processing element for one time step of a four-point Laplace (Jacobi) update over a two-dimensional grid of `COLS` columns. The grid enters in row-major order, four neighbouring cells per beat. Every cell is fetched from the stream exactly once. A shared sliding window keeps the rows needed for reuse: three rows of cells in eight line delays and fourteen registers. Each accepted beat produces one output beat carrying four updated cells of the centre row. Each updated cell is the mean of its four orthogonal neighbours.

The element sits inside a longer pipeline. Its input and output are valid/ready streams, and the stages are coupled so that one condition freezes the whole window: missing input data or back-pressure from downstream. Cells are 16-bit signed two's complement values. In the first and last grid columns the centre value passes through unchanged. The first and last rows are never emitted. After the first row the stream is continuous, so a new grid is started with a reset.

Top module: `stencil_row4_pe`

## Requirements
- R1: Lane k (k = 0..3) of a beat sits in bits [16k+15:16k] and carries column 4j+k of the row, where j is the beat's position within the row (COLS/4 beats per row).
- R2: For an interior cell, the output is the sum of its upper, lower, left and right neighbours formed at 18 bits and then shifted right arithmetically by 2, so the result is rounded toward minus infinity.
- R3: Cells in column 0 and column COLS-1 are output equal to their input value.
- R4: `out_valid` stays low until 2·COLS/4+1 input beats have been accepted. The first output beat carries row 1, columns 0..3.
- R5: After the fill, each accepted input beat transfers exactly one output beat. Output beats follow the centre row in row-major order, starting at row 1. A grid of N rows, followed by one further beat, yields rows 1..N-2 complete.
- R6: A beat is accepted only when `in_valid` and `out_ready` are both high. Otherwise no state advances, `out_valid` is low whenever `in_valid` is low, and `out_data` holds its value.
- R7: `in_ready` equals `out_ready` in every cycle.
- R8: Following reset, `out_valid` is low even when input is offered.
- R9: Sums that exceed the 16-bit range do not wrap: four neighbours at +32767 give +32767, and four at -32768 give -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Element can take a beat |
| in_data | input | 64 | Four input cells, lane k at [16k+15:16k] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 64 | Four updated cells, same lane order |

## Verification
The hardest situation to reach from the ports is a window that stays exactly aligned while the stream is stopped at arbitrary phases. Input gaps and output back-pressure must land on the edge-column beats, in the middle of the fill and on the row wrap, and data must be held through each stop. The stall scenario drives `in_valid` and `out_ready` from two modulo patterns of different periods. Across one grid, stops therefore fall at every beat position. A further grid uses only the most positive and most negative cell values, which forces the 18-bit sum to its limits.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int CELL_W = 16;
  localparam int LANES  = 4;
  localparam int SUM_W  = CELL_W + 2;

  typedef logic signed [CELL_W-1:0] cell_t;
  typedef cell_t [LANES-1:0]        beat_t;

  // Mean of four neighbours: widened sum, arithmetic shift by two.
  function automatic cell_t avg4(input cell_t a, input cell_t b,
                                 input cell_t c, input cell_t d);
    logic signed [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b) + SUM_W'(c) + SUM_W'(d);
    s = s >>> 2;
    return s[CELL_W-1:0];
  endfunction
endpackage

// File: rtl/stencil_line_delay.sv
module stencil_line_delay #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Push and pop happen together, so the queue is a fixed delay of DEPTH steps.
  if (DEPTH == 0) begin : g_wire
    assign dout = din;
  end else if (DEPTH == 1) begin : g_reg
    logic [WIDTH-1:0] hold_q;
    assign dout = hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hold_q <= '0;
      else if (en) hold_q <= din;
    end
  end else begin : g_ring
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;
    assign dout = mem[ptr];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr <= '0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (en) begin
        mem[ptr] <= din;
        ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stencil_window.sv
module stencil_window
  import stencil_pkg::*;
#(
  parameter int COLS = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  beat_t in_beat,
  output beat_t up_q,
  output beat_t ctr_q,
  output beat_t dn_q,
  output cell_t lft_q,
  output cell_t rgt_q
);
  localparam int BEATS   = COLS / LANES;
  localparam int LONG_D  = BEATS - 1;  // aligned lanes
  localparam int SHORT_D = BEATS - 2;  // lanes that feed or come from the skewed registers

  beat_t upper_out, lower_in, lower_out;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // Upper queues: newest row -> centre row. Lane 0 runs one beat ahead (right neighbour).
    stencil_line_delay #(.WIDTH(CELL_W), .DEPTH(k == 0 ? SHORT_D : LONG_D)) u_upper (
      .clk(clk), .rst_n(rst_n), .en(en), .din(up_q[k]), .dout(upper_out[k]));

    // Lower queues: centre row -> oldest row. Lane 3 is fed from the left register.
    if (k == LANES - 1) begin : g_from_left
      assign lower_in[k] = lft_q;
    end else begin : g_from_ctr
      assign lower_in[k] = ctr_q[k];
    end
    stencil_line_delay #(.WIDTH(CELL_W), .DEPTH(k == LANES - 1 ? SHORT_D : LONG_D)) u_lower (
      .clk(clk), .rst_n(rst_n), .en(en), .din(lower_in[k]), .dout(lower_out[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      ctr_q <= '0;
      dn_q  <= '0;
      lft_q <= '0;
      rgt_q <= '0;
    end else if (en) begin
      up_q          <= in_beat;
      rgt_q         <= upper_out[0];
      ctr_q[0]      <= rgt_q;
      ctr_q[LANES-1:1] <= upper_out[LANES-1:1];
      lft_q         <= ctr_q[LANES-1];
      dn_q          <= lower_out;
    end
  end
endmodule

// File: rtl/stencil_lanes.sv
module stencil_lanes
  import stencil_pkg::*;
(
  input  beat_t up,
  input  beat_t ctr,
  input  beat_t dn,
  input  cell_t lft,
  input  cell_t rgt,
  input  logic  at_left,
  input  logic  at_right,
  output beat_t res
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cell_t west, east;
    logic  keep;
    if (k == 0) begin : g_w_edge
      assign west = lft;
      assign keep = at_left;
    end else begin : g_w_in
      assign west = ctr[k-1];
    end
    if (k == LANES - 1) begin : g_e_edge
      assign east = rgt;
      assign keep = at_right;
    end else begin : g_e_in
      assign east = ctr[k+1];
    end
    if (k != 0 && k != LANES - 1) begin : g_mid
      assign keep = 1'b0;
    end
    assign res[k] = keep ? ctr[k] : avg4(up[k], dn[k], west, east);
  end
endmodule

// File: rtl/stencil_row4_pe.sv
module stencil_row4_pe
  import stencil_pkg::*;
#(
  parameter int COLS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*CELL_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*CELL_W-1:0] out_data
);
  localparam int BEATS      = COLS / LANES;
  localparam int FILL_BEATS = 2 * BEATS + 1;
  localparam int CNT_W      = $clog2(FILL_BEATS + 1);
  localparam int COL_W      = $clog2(BEATS);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_BEATS);
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(BEATS - 1);

  // Named internal events for the checker.
  logic  step_w;
  logic  fill_done_w;
  logic  edge_left_w, edge_right_w;
  beat_t ctr_beat_w;

  logic [CNT_W-1:0] fill_q;
  logic [COL_W-1:0] col_q;   // beat column of the newest row = column of the centre beat
  beat_t up_w, dn_w, res_w, in_beat;
  cell_t lft_w, rgt_w;

  assign in_ready     = out_ready;
  assign step_w       = in_valid & out_ready;
  assign fill_done_w  = (fill_q == FILL_LAST);
  assign edge_left_w  = (col_q == '0);
  assign edge_right_w = (col_q == COL_LAST);
  assign out_valid    = fill_done_w & in_valid;
  assign in_beat      = in_data;
  assign out_data     = res_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      col_q  <= COL_LAST;
    end else if (step_w) begin
      if (!fill_done_w) fill_q <= fill_q + 1'b1;
      col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    end
  end

  stencil_window #(.COLS(COLS)) u_window (
    .clk(clk), .rst_n(rst_n), .en(step_w), .in_beat(in_beat),
    .up_q(up_w), .ctr_q(ctr_beat_w), .dn_q(dn_w), .lft_q(lft_w), .rgt_q(rgt_w));

  stencil_lanes u_lanes (
    .up(up_w), .ctr(ctr_beat_w), .dn(dn_w), .lft(lft_w), .rgt(rgt_w),
    .at_left(edge_left_w), .at_right(edge_right_w), .res(res_w));
endmodule

// File: rtl/stencil_row4_pe_chk.sv
module stencil_row4_pe_chk #(
  parameter int COLS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        edge_left_w,
  input logic        edge_right_w,
  input logic [63:0] ctr_beat_w
);
  localparam int FILL = 2 * (COLS / 4) + 1;
  localparam int AW   = $clog2(FILL + 1);
  localparam logic [AW-1:0] FILL_V = AW'(FILL);

  logic [AW-1:0] acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (in_valid && in_ready && acc_q != FILL_V) acc_q <= acc_q + 1'b1;
  end

  // R4: no output before the window has taken the fill beats
  a_r4_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q == FILL_V));

  // R5: an output transfer coincides with an input acceptance
  a_r5_out_with_in: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (in_valid && in_ready));

  // R6: a cycle without acceptance leaves the output beat unchanged
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));

  // R3: edge lanes carry the centre cell through
  a_r3_left_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && edge_left_w) |-> (out_data[15:0] == ctr_beat_w[15:0]));
  a_r3_right_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && edge_right_w) |-> (out_data[63:48] == ctr_beat_w[63:48]));
endmodule

bind stencil_row4_pe stencil_row4_pe_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .edge_left_w(edge_left_w), .edge_right_w(edge_right_w), .ctr_beat_w(ctr_beat_w));

// File: tb/stencil_row4_pe_tb.sv
module stencil_row4_pe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COLS  = 16;
  localparam int ROWS  = 6;
  localparam int BEATS = COLS / 4;
  localparam int FILL  = 2 * BEATS + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int grid [ROWS][COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  stencil_row4_pe #(.COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int quarter_floor(input int s);
    if (s >= 0) return s / 4;
    return -((-s + 3) / 4);
  endfunction

  function automatic int expect_cell(input int o, input int k);
    int c, row, x, s;
    c   = BEATS + o;
    row = c / BEATS;
    x   = 4 * (c % BEATS) + k;
    if (x == 0 || x == COLS - 1) return grid[row][x];
    s = grid[row-1][x] + grid[row+1][x] + grid[row][x-1] + grid[row][x+1];
    return quarter_floor(s);
  endfunction

  function automatic int lane_of(input logic [63:0] d, input int k);
    logic signed [15:0] v;
    v = d[16*k +: 16];
    return int'(v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Stream the stored grid plus one trailing beat; check every output beat.
  task automatic run_frame(input int gap_mod, input int ready_mod, input string tag);
    int b = 0, o = 0, cyc = 0;
    bit prev_hold = 1'b0;
    logic [63:0] prev_data = '0;
    while (b <= ROWS * BEATS) begin
      @(negedge clk);
      in_valid  = (gap_mod == 0) || (cyc % gap_mod != 0);
      out_ready = (ready_mod == 0) || (cyc % ready_mod != 1);
      for (int k = 0; k < 4; k++)
        in_data[16*k +: 16] = (b < ROWS * BEATS) ? 16'(grid[b / BEATS][4 * (b % BEATS) + k]) : 16'h0;
      #1;
      if (cyc < 3) chk("R7 in_ready follows out_ready", int'(in_ready), int'(out_ready));
      chk("R4/R6 out_valid", int'(out_valid), int'(b >= FILL && in_valid));
      if (prev_hold && out_valid)
        for (int k = 0; k < 4; k++) chk("R6 data held", lane_of(out_data, k), lane_of(prev_data, k));
      if (out_valid && out_ready) begin
        for (int k = 0; k < 4; k++) begin
          int x = 4 * ((BEATS + o) % BEATS) + k;
          string t = (x == 0 || x == COLS - 1) ? "R3 edge" : "R1/R2 lane";
          chk($sformatf("%s %s out%0d lane%0d", tag, t, o, k), lane_of(out_data, k), expect_cell(o, k));
        end
        o++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (in_valid && out_ready) b++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R5 output beat count"}, o, (ROWS - 2) * BEATS);
  endtask

  task automatic t_reset_state();
    do_reset();
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk("R8 out_valid after reset", int'(out_valid), 0);
    chk("R7 in_ready high", int'(in_ready), 1);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R7 in_ready low", int'(in_ready), 0);
    chk("R8 out_valid still low", int'(out_valid), 0);
    in_valid = 1'b0;
  endtask

  task automatic t_ramp();
    for (int r = 0; r < ROWS; r++)
      for (int x = 0; x < COLS; x++) grid[r][x] = r * 37 + x * 5 - 100 + ((x * x) % 7);
    do_reset();
    run_frame(0, 0, "ramp");
  endtask

  task automatic t_extremes();
    for (int r = 0; r < ROWS; r++)
      for (int x = 0; x < COLS; x++)
        grid[r][x] = (r < 3) ? 32767 : -32768;
    grid[1][5] = -32768;
    grid[4][9] = 32767;
    do_reset();
    run_frame(0, 0, "R9 extremes");
  endtask

  task automatic t_stall();
    int seed = 12345;
    for (int r = 0; r < ROWS; r++)
      for (int x = 0; x < COLS; x++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        grid[r][x] = ((seed >> 8) % 65536) - 32768;
      end
    do_reset();
    run_frame(3, 4, "R6 stall");
  endtask

  initial begin
    t_reset_state();
    t_ramp();
    t_extremes();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule